// File: doc/BRIEF.md
# Continuous-Mode SPI Master Shifter

This block is a synchronous serial master that sends and receives one word at the same time. Each write on the host side is placed in a single holding slot that sits in front of the shift engine. The slot empties into the shift engine when a frame starts, and a single-cycle buffer-empty event marks that moment. If the host refills the slot before the running frame ends, the next frame begins on the very clock edge that ends the current one. The serial clock therefore keeps running with no idle gap between frames.

The serial clock is low when idle. Data-out changes on its falling edge, and data-in is sampled on its rising edge. The first bit of a frame is already on data-out one half serial period before the first rising edge. The half period, the frame length (8 to 16 bits) and the bit order come from configuration inputs. They are latched when a frame starts, so a change made mid-frame affects only later frames.

At the end of each frame the received word is latched into a read register and a single-cycle receive-complete event pulses. An overrun flag reports a word that was replaced before the host read it. A sticky flag reports a write attempted while the holding slot was already full.

Top module: `spi_stream_master`

## Requirements
- R1: While reset is active and right after it is released, sclk, mosi, busy, tx_empty_evt, rx_done_evt, rx_valid, rx_overrun and tx_write_err are all 0, and rx_data is 0.
- R2: A tx_wr pulse with the holding slot empty stores tx_data. busy is 1 from the next cycle. On the following edge the word moves into the shift engine, and tx_empty_evt is 1 for exactly the one cycle after that edge.
- R3: Each serial clock phase lasts cfg_half_div+1 module clocks. A value of 0 gives sclk at the module clock divided by 2. The first phase of a frame is low.
- R4: The frame length is cfg_len, taken as 8 when below 8 and as 16 when above 16. A frame has exactly that many sclk rising edges.
- R5: With cfg_lsb_first=0 the bit at position length-1 goes out first (MSB first). With 1, bit 0 goes out first. mosi changes only at a falling edge of sclk or at frame start, and holds while sclk is high.
- R6: miso is sampled at each sclk rising edge. The received word is placed right-aligned in rx_data using the same bit order as transmission, and bits at and above the frame length read 0.
- R7: At the end of each frame, rx_data takes the received word, rx_valid becomes 1, and rx_done_evt is 1 for one cycle. An rx_rd pulse clears rx_valid.
- R8: If the holding slot is full when a frame ends, the next frame starts on the same edge. Consecutive tx_empty_evt pulses are then exactly 2*(cfg_half_div+1)*length cycles apart.
- R9: If the holding slot is empty when a frame ends, busy and sclk go to 0 and stay there until the next write.
- R10: A frame end while rx_valid is 1 and rx_rd is 0 sets rx_overrun. An rx_rd pulse without a frame end in the same cycle clears it.
- R11: A tx_wr while the holding slot is full leaves the slot unchanged and sets tx_write_err. tx_write_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_div | input | 8 | Serial clock half period minus one, in module clocks |
| cfg_len | input | 5 | Frame length in bits (clamped to 8..16) |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| tx_wr | input | 1 | Write strobe for the holding slot |
| tx_data | input | 16 | Word to transmit (low bits used) |
| rx_rd | input | 1 | Read acknowledge for the received word |
| rx_data | output | 16 | Last received word, right-aligned |
| rx_valid | output | 1 | Unread received word present |
| busy | output | 1 | Frame running or word pending |
| tx_empty_evt | output | 1 | One-cycle pulse when the slot empties into the shifter |
| rx_done_evt | output | 1 | One-cycle pulse when a received word is latched |
| rx_overrun | output | 1 | Received word replaced before it was read |
| tx_write_err | output | 1 | Sticky: write attempted to a full slot |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach is the seamless handover. Here the end of one frame, the load of the next, both event pulses and possibly an overrun all fall on a single edge. The stimulus refills the slot as soon as the buffer-empty event is seen, and it deliberately leaves the first word unread, so that the pulse spacing, the overrun and both words can be checked at that edge. A long random phase then mixes refills, writes to a full slot, reads that coincide with frame ends, and configuration changes in the middle of a frame. A behavioural model built on bit queues follows this phase on every clock.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } order_e;

endpackage

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [WORD_W-1:0] data_o,
    output logic              werr_o
);

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] data;
        logic              werr;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (take_i) begin
            d.full = 1'b0;
        end
        if (wr_i) begin
            if (q.full) begin
                d.werr = 1'b1;
            end else begin
                d.full = 1'b1;
                d.data = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign full_o = q.full;
    assign data_o = q.data;
    assign werr_o = q.werr;

    // R11: the error flag never clears on its own
    p_werr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.werr |=> q.werr);

    // R11: a full slot that is not taken keeps its word whatever is written
    p_full_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !take_i) |=> (q.full && $stable(q.data)));

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_stream_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 8,
    parameter int DIV_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DIV_W-1:0]             half_div_i,
    input  logic [$clog2(MAX_LEN+1)-1:0] len_i,
    input  logic                         lsb_first_i,
    input  logic                         buf_full_i,
    input  logic [MAX_LEN-1:0]           buf_data_i,
    input  logic                         miso_i,
    output logic                         take_o,
    output logic                         frame_done_o,
    output logic [MAX_LEN-1:0]           frame_word_o,
    output logic                         active_o,
    output logic                         sclk_o,
    output logic                         mosi_o,
    output logic                         tx_empty_o
);

    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);

    typedef struct packed {
        logic               active;
        logic               sclk;
        logic [DIV_W-1:0]   tick;
        logic [DIV_W-1:0]   half;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        order_e             order;
        logic [MAX_LEN-1:0] tx;
        logic [MAX_LEN-1:0] rx;
        logic               txe;
    } eng_t;

    eng_t q, d;

    logic [LEN_W-1:0] len_eff;
    logic [IDX_W-1:0] bit_pos;
    logic             phase_end;
    logic             frame_end;
    logic             take;

    // Frame length clamped into the supported window
    always_comb begin
        if (len_i < LEN_W'(MIN_LEN)) begin
            len_eff = LEN_W'(MIN_LEN);
        end else if (len_i > LEN_W'(MAX_LEN)) begin
            len_eff = LEN_W'(MAX_LEN);
        end else begin
            len_eff = len_i;
        end
    end

    always_comb begin
        bit_pos   = (q.order == ORDER_LSB) ? q.idx : (q.last - q.idx);
        phase_end = q.active && (q.tick == q.half);
        frame_end = phase_end && q.sclk && (q.idx == q.last);
        take      = buf_full_i && (!q.active || frame_end);

        d     = q;
        d.txe = 1'b0;

        if (q.active) begin
            if (!phase_end) begin
                d.tick = q.tick + 1'b1;
            end else begin
                d.tick = '0;
                if (!q.sclk) begin
                    d.sclk        = 1'b1;
                    d.rx[bit_pos] = miso_i;
                end else if (q.idx == q.last) begin
                    d.active = 1'b0;
                    d.sclk   = 1'b0;
                end else begin
                    d.sclk = 1'b0;
                    d.idx  = q.idx + 1'b1;
                end
            end
        end

        if (take) begin
            d.active = 1'b1;
            d.sclk   = 1'b0;
            d.tick   = '0;
            d.half   = half_div_i;
            d.idx    = '0;
            d.last   = IDX_W'(len_eff - 1'b1);
            d.order  = order_e'(lsb_first_i);
            d.tx     = buf_data_i;
            d.rx     = '0;
            d.txe    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign take_o       = take;
    assign frame_done_o = frame_end;
    assign frame_word_o = q.rx;
    assign active_o     = q.active;
    assign sclk_o       = q.sclk;
    assign mosi_o       = q.active & q.tx[bit_pos];
    assign tx_empty_o   = q.txe;

    // R9: no serial clock activity without a running frame
    p_idle_sclk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.sclk);

    // R5: data out holds through a high phase
    p_mosi_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(mosi_o));

    // R2: every handover is followed by the buffer-empty event
    p_take_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> q.txe);

    // R4: bit index never passes the latched length
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.idx <= q.last));

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              done;
        logic              ovr;
    } rxh_t;

    rxh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (frame_done_i) begin
            d.data  = word_i;
            d.valid = 1'b1;
            d.done  = 1'b1;
            if (q.valid && !rd_i) begin
                d.ovr = 1'b1;
            end else if (rd_i) begin
                d.ovr = 1'b0;
            end
        end else if (rd_i) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign done_o  = q.done;
    assign ovr_o   = q.ovr;

    // R7: the completion event always comes with a readable word
    p_done_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.valid);

    // R10: replacing an unread word raises overrun
    p_ovr_on_unread_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && q.valid && !rd_i) |=> q.ovr);

endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master #(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 8,
    parameter int DIV_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DIV_W-1:0]             cfg_half_div,
    input  logic [$clog2(MAX_LEN+1)-1:0] cfg_len,
    input  logic                         cfg_lsb_first,
    input  logic                         tx_wr,
    input  logic [MAX_LEN-1:0]           tx_data,
    input  logic                         rx_rd,
    output logic [MAX_LEN-1:0]           rx_data,
    output logic                         rx_valid,
    output logic                         busy,
    output logic                         tx_empty_evt,
    output logic                         rx_done_evt,
    output logic                         rx_overrun,
    output logic                         tx_write_err,
    output logic                         sclk,
    output logic                         mosi,
    input  logic                         miso
);

    logic               slot_full;
    logic [MAX_LEN-1:0] slot_data;
    logic               take;
    logic               frame_done;
    logic [MAX_LEN-1:0] frame_word;
    logic               active;

    spi_tx_hold #(.WORD_W(MAX_LEN)) u_tx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (tx_wr),
        .wr_data_i (tx_data),
        .take_i    (take),
        .full_o    (slot_full),
        .data_o    (slot_data),
        .werr_o    (tx_write_err)
    );

    spi_bit_engine #(
        .MAX_LEN (MAX_LEN),
        .MIN_LEN (MIN_LEN),
        .DIV_W   (DIV_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_div_i   (cfg_half_div),
        .len_i        (cfg_len),
        .lsb_first_i  (cfg_lsb_first),
        .buf_full_i   (slot_full),
        .buf_data_i   (slot_data),
        .miso_i       (miso),
        .take_o       (take),
        .frame_done_o (frame_done),
        .frame_word_o (frame_word),
        .active_o     (active),
        .sclk_o       (sclk),
        .mosi_o       (mosi),
        .tx_empty_o   (tx_empty_evt)
    );

    spi_rx_hold #(.WORD_W(MAX_LEN)) u_rx_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .word_i       (frame_word),
        .rd_i         (rx_rd),
        .data_o       (rx_data),
        .valid_o      (rx_valid),
        .done_o       (rx_done_evt),
        .ovr_o        (rx_overrun)
    );

    assign busy = active | slot_full;

endmodule

// File: tb/spi_stream_master_test.sv
module spi_stream_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half_div = 8'd0;
    logic [4:0]  cfg_len = 5'd8;
    logic        cfg_lsb_first = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_data;
    logic        rx_valid, busy, tx_empty_evt, rx_done_evt, rx_overrun, tx_write_err;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic        loopback = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    spi_stream_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div), .cfg_len(cfg_len),
        .cfg_lsb_first(cfg_lsb_first), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .tx_empty_evt(tx_empty_evt),
        .rx_done_evt(rx_done_evt), .rx_overrun(rx_overrun), .tx_write_err(tx_write_err),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [4:0] l);
        if (l < 5'd8) return 8;
        if (l > 5'd16) return 16;
        return int'(l);
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          tq[$];
    bit          rq[$];
    logic [15:0] pend[$];
    int          m_act, m_lvl, m_tick, m_half, m_len, m_lsb;
    logic        m_txe, m_rxd, m_rxv, m_ovr, m_werr;
    logic [15:0] m_rxw;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            tq.delete(); rq.delete(); pend.delete();
            m_act = 0; m_lvl = 0; m_tick = 0; m_half = 1; m_len = 8; m_lsb = 0;
            m_txe = 0; m_rxd = 0; m_rxv = 0; m_ovr = 0; m_werr = 0; m_rxw = 0;
        end else begin
            bit ending;
            bit was_act;
            bit was_full;
            logic [15:0] w;
            ending   = 0;
            was_act  = (m_act != 0);
            was_full = (pend.size() != 0);
            m_txe = 0;
            m_rxd = 0;
            if (was_act) begin
                if (m_tick < m_half - 1) begin
                    m_tick++;
                end else begin
                    m_tick = 0;
                    if (m_lvl == 0) begin
                        m_lvl = 1;
                        rq.push_back(miso);
                    end else if (tq.size() == 1) begin
                        ending = 1;
                    end else begin
                        m_lvl = 0;
                        void'(tq.pop_front());
                    end
                end
            end
            if (ending) begin
                w = '0;
                for (int i = 0; i < rq.size(); i++) begin
                    if (m_lsb != 0) w[i] = rq[i];
                    else            w[m_len - 1 - i] = rq[i];
                end
                if (m_rxv && !rx_rd) m_ovr = 1;
                else if (rx_rd)      m_ovr = 0;
                m_rxv = 1; m_rxw = w; m_rxd = 1;
                m_act = 0; m_lvl = 0;
                tq.delete(); rq.delete();
            end else if (rx_rd) begin
                m_rxv = 0; m_ovr = 0;
            end
            if (was_full && (!was_act || ending)) begin
                logic [15:0] nw;
                nw     = pend.pop_front();
                m_len  = eff_len(cfg_len);
                m_lsb  = int'(cfg_lsb_first);
                m_half = int'(cfg_half_div) + 1;
                m_act = 1; m_lvl = 0; m_tick = 0; m_txe = 1;
                tq.delete(); rq.delete();
                for (int i = 0; i < m_len; i++) begin
                    if (m_lsb != 0) tq.push_back(nw[i]);
                    else            tq.push_back(nw[m_len - 1 - i]);
                end
            end
            if (tx_wr) begin
                if (was_full) m_werr = 1;
                else          pend.push_back(tx_data);
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 sclk", sclk, m_lvl[0]);
            chk("R5 mosi", mosi, (m_act != 0) ? tq[0] : 1'b0);
            chk("R9 busy", busy, (m_act != 0) || (pend.size() != 0));
            chk("R2 tx_empty_evt", tx_empty_evt, m_txe);
            chk("R7 rx_done_evt", rx_done_evt, m_rxd);
            chk("R7 rx_valid", rx_valid, m_rxv);
            chk("R6 rx_data", rx_data, m_rxw);
            chk("R10 rx_overrun", rx_overrun, m_ovr);
            chk("R11 tx_write_err", tx_write_err, m_werr);
        end
    end

    // serial partner: loop back or random bits, changed away from the sampling edge
    always @(negedge clk) begin
        miso <= loopback ? mosi : 1'($urandom);
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic put(input logic [15:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic take_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // single loopback frame: check length, data, first bit and idle return
    task automatic one_frame(input logic [15:0] d, input int len, input logic lsb, input string tag);
        int rises;
        logic prev;
        logic [15:0] mask;
        rises = 0;
        prev  = 1'b0;
        mask  = 16'((32'h1 << len) - 1);
        put(d);
        chk({tag, " R2 busy after write"}, busy, 1'b1);
        do @(negedge clk); while (!tx_empty_evt);
        chk({tag, " R5 first bit"}, mosi, lsb ? d[0] : d[len-1]);
        chk({tag, " R3 first phase low"}, sclk, 1'b0);
        do begin
            @(negedge clk);
            if (sclk && !prev) rises++;
            prev = sclk;
        end while (!rx_done_evt);
        chk({tag, " R4 rising edges"}, rises, len);
        chk({tag, " R6 loopback word"}, rx_data, d & mask);
        chk({tag, " R7 valid"}, rx_valid, 1'b1);
        chk({tag, " R9 idle busy"}, busy, 1'b0);
        chk({tag, " R9 idle sclk"}, sclk, 1'b0);
        take_rx();
        chk({tag, " R7 read clears valid"}, rx_valid, 1'b0);
    endtask

    initial begin
        int t1;
        int t2;
        repeat (3) @(negedge clk);
        chk("R1 sclk in reset", sclk, 1'b0);
        chk("R1 busy in reset", busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sclk", sclk, 1'b0);
        chk("R1 mosi", mosi, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 events", {tx_empty_evt, rx_done_evt}, 2'b00);
        chk("R1 flags", {rx_valid, rx_overrun, tx_write_err}, 3'b000);
        chk("R1 rx_data", rx_data, 16'h0);

        // 8-bit MSB first, sclk = clk/2
        one_frame(16'h00A5, 8, 1'b0, "f8msb");

        // 12-bit LSB first, half period 3 clocks
        cfg_half_div = 8'd2; cfg_len = 5'd12; cfg_lsb_first = 1'b1;
        one_frame(16'h09A7, 12, 1'b1, "f12lsb");

        // clamping of the length
        cfg_half_div = 8'd0; cfg_lsb_first = 1'b0;
        cfg_len = 5'd3;
        one_frame(16'h01FF, 8, 1'b0, "len3");
        cfg_len = 5'd20;
        one_frame(16'hF00F, 16, 1'b0, "len20");

        // back-to-back frames with an unread first word
        cfg_len = 5'd8; cfg_half_div = 8'd0;
        put(16'h003C);
        do @(negedge clk); while (!tx_empty_evt);
        t1 = cyc;
        put(16'h00C3);
        do @(negedge clk); while (!tx_empty_evt);
        t2 = cyc;
        chk("R8 no gap between frames", t2 - t1, 16);
        chk("R8 first word at handover", rx_data, 16'h003C);
        chk("R7 done at handover", rx_done_evt, 1'b1);
        do @(negedge clk); while (!rx_done_evt);
        chk("R8 second word", rx_data, 16'h00C3);
        chk("R10 overrun set", rx_overrun, 1'b1);
        take_rx();
        chk("R10 read clears overrun", rx_overrun, 1'b0);

        // write into a full slot
        put(16'h0011);
        do @(negedge clk); while (!tx_empty_evt);
        put(16'h0022);
        chk("R11 no error yet", tx_write_err, 1'b0);
        put(16'h0033);
        chk("R11 error set", tx_write_err, 1'b1);
        do @(negedge clk); while (!rx_done_evt);
        take_rx();
        do @(negedge clk); while (!rx_done_evt);
        chk("R11 rejected word not sent", rx_data, 16'h0022);
        take_rx();
        chk("R11 error sticky", tx_write_err, 1'b1);

        // random traffic against the model
        loopback = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tx_wr   = ($urandom % 6) == 0;
            tx_data = 16'($urandom);
            rx_rd   = ($urandom % 4) == 0;
            if (($urandom % 150) == 0) begin
                cfg_half_div  = 8'($urandom % 3);
                cfg_len       = 5'(6 + ($urandom % 13));
                cfg_lsb_first = 1'($urandom);
            end
        end
        @(negedge clk);
        tx_wr = 1'b0;
        rx_rd = 1'b0;
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R9 final idle busy", busy, 1'b0);
        chk("R9 final idle sclk", sclk, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule